// File: doc/BRIEF.md
# Two-Cycle Masked Wide-Key Search Engine

This block holds a small table of 72-bit words and searches it for a 144-bit key. The key arrives over two consecutive command cycles on a 72-bit data bus. The first cycle carries the upper key half, which is compared with every even-numbered word. The second cycle carries the lower half, which is compared with every odd-numbered word. Each half passes through its own mask register, taken from a global mask pair that the first cycle selects. A 144-bit entry is an even word followed by the next odd word. It hits only when both of its halves match.

The lowest hitting entry wins. Its even word index is reported, prefixed by three address bits taken from the first cycle, together with a hit flag. The result leaves the block after a base latency set by a table-size field, plus 0 to 7 extra cycles from a hit-latency field. The same result is stored in one of eight search-result registers. The second cycle also names a comparand pair, which keeps the full 144-bit key. A plain write port loads the table words, the mask registers and the comparand registers. A combinational read port returns a comparand pair or a search-result register.

Top module: `nse_search_top`

## Requirements
- R1: Cycle A is accepted when `cmd_vld`=1, `cmd[1:0]`=2'b10, `cmd[2]`=0 and no cycle A is pending. The following cycle must be a search cycle (`cmd_vld`=1 and `cmd[1:0]`=2'b10). Otherwise the pending cycle A is dropped and produces no result.
- R2: Let g={`cmd[10]`,`cmd[5:3]`} in cycle A, let M be the mask registers (mask bit 1 = compare) and let E be the table words. Pair p hits when ((E[2p]^A)&M[2g])==0 and ((E[2p+1]^B)&M[2g+1])==0. A is the cycle A data and B is the cycle B data.
- R3: On a hit, `res_hit`=1. `res_addr[20:0]` is 2p for the lowest hitting pair p, and `res_addr[23:21]` is `cmd[8:6]` from cycle A.
- R4: When no pair hits, `res_hit`=0.
- R5: `res_vld` is high for exactly one cycle. That cycle is L cycles after the cycle carrying cycle B, where L=base+`hit_lat`. base is 4 for `tbl_size`=00, 5 for 01, and 6 for 10 or 11.
- R6: Cycle B `cmd[8:6]` is the search-result register index. It appears on `res_ssr`. At the end of the `res_vld` cycle that register takes {hit, addr}. It reads back on `rd_data[24:0]` with `rd_sel`=1 and `rd_idx`=index.
- R7: Cycle B `cmd[5:2]` selects a comparand pair, which stores {A,B}. It reads back with `rd_sel`=0. A same-cycle write-port write to that pair loses to the capture.
- R8: A search cycle with `cmd[2]`=1 and no pending cycle A is ignored and produces no result.
- R9: Searches may be issued every two cycles. Their results come out in issue order, each with its own latency.
- R10: After reset, `res_vld`=0 and all search-result registers read 0.
- R11: The write port selects its target with `wr_sel`: 0 = table word `wr_addr`, 1 = mask register `wr_addr`, 2 = comparand pair `wr_addr[4:1]`. For a comparand pair, `wr_addr[0]`=0 picks the upper half and 1 picks the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_vld | input | 1 | Command valid strobe |
| cmd | input | 11 | Command code and fields |
| dq | input | 72 | Key half for the current command cycle |
| tbl_size | input | 2 | Table-size field selecting the base latency |
| hit_lat | input | 3 | Extra result latency in cycles |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target class |
| wr_addr | input | 5 | Write target index |
| wr_data | input | 72 | Write data |
| rd_sel | input | 1 | 0 = comparand pair, 1 = search-result register |
| rd_idx | input | 4 | Read index |
| rd_data | output | 144 | Read data |
| res_vld | output | 1 | Result strobe |
| res_hit | output | 1 | Hit flag |
| res_addr | output | 24 | Matching entry address |
| res_ssr | output | 3 | Search-result register index of this result |

## Verification
Two functions can fall in the same cycle. One is the comparand capture made by cycle B. The other is a write-port write aimed at the same comparand pair. The bench drives both in one clock. It then reads the pair back and expects the captured key, never the written word. A second overlap comes from back-to-back searches: one search's cycle A can coincide with an earlier search still in the latency pipe. This is judged by matching each result against its own expected cycle, address and register index.

// File: rtl/nse_pkg.sv
package nse_pkg;
   localparam int          CMD_W      = 11;
   localparam logic [1:0]  CMD_SEARCH = 2'b10;
   localparam int          RADDR_W    = 24;
   localparam int          RLOW_W     = 21;
   localparam int          SSR_N      = 8;
   localparam int          PAIR_IDX_W = 4;

   localparam logic [1:0]  WR_WORD = 2'd0;
   localparam logic [1:0]  WR_MASK = 2'd1;
   localparam logic [1:0]  WR_CMP  = 2'd2;

   typedef struct packed {
      logic                vld;
      logic                hit;
      logic [RADDR_W-1:0]  addr;
      logic [2:0]          ssr;
   } nse_res_t;
endpackage

// File: rtl/nse_match_bank.sv
module nse_match_bank #(
   parameter int WORD_W  = 72,
   parameter int WORDS   = 16,
   parameter int AW      = 5
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [WORD_W-1:0] key,
   input  logic [WORD_W-1:0] care,
   output logic [WORDS-1:0]  hit
);
   generate
      for (genvar j = 0; j < WORDS; j++) begin : g_word
         logic [WORD_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == AW'(j)))
               word_q <= wr_data;
         end
         assign hit[j] = (((word_q ^ key) & care) == '0);
      end
   endgenerate
endmodule

// File: rtl/nse_prio_enc.sv
module nse_prio_enc #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/nse_lat_pipe.sv
module nse_lat_pipe
   import nse_pkg::*;
#(
   parameter int BASE_S = 4,
   parameter int BASE_M = 5,
   parameter int BASE_L = 6,
   parameter int XTRA_W = 3,
   localparam int DEPTH = BASE_L + (1 << XTRA_W) - 1,
   localparam int TW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        tbl_size,
   input  logic [XTRA_W-1:0] hit_lat,
   input  nse_res_t          din,
   output nse_res_t          dout
);
   nse_res_t stage [DEPTH];
   logic [TW-1:0] tap;

   if (BASE_S < 1 || BASE_M < BASE_S || BASE_L < BASE_M) begin : g_bad_base
      $error("nse_lat_pipe: base latencies must be ordered and at least 1");
   end

   always_comb begin
      case (tbl_size)
         2'b00:   tap = TW'(BASE_S - 1) + TW'(hit_lat);
         2'b01:   tap = TW'(BASE_M - 1) + TW'(hit_lat);
         default: tap = TW'(BASE_L - 1) + TW'(hit_lat);
      endcase
   end

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[s] <= '0;
            else if (s == 0) stage[s] <= din;
            else stage[s] <= stage[(s == 0) ? 0 : s - 1];
         end
      end
   endgenerate

   assign dout = stage[tap];

   // R5
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout.vld |=> !dout.vld);
endmodule

// File: rtl/nse_search_top.sv
module nse_search_top
   import nse_pkg::*;
#(
   parameter int DATA_W  = 72,
   parameter int WORDS   = 16,
   parameter int BASE_S  = 4,
   parameter int BASE_M  = 5,
   parameter int BASE_L  = 6,
   localparam int PAIRS  = WORDS / 2,
   localparam int PIW    = (PAIRS > 1) ? $clog2(PAIRS) : 1,
   localparam int NMASK  = 2 << PAIR_IDX_W,
   localparam int NCMP   = 1 << PAIR_IDX_W,
   localparam int WAW_RAW = $clog2((WORDS > NMASK) ? WORDS : NMASK),
   localparam int WAW    = (WAW_RAW < 5) ? 5 : WAW_RAW
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_vld,
   input  logic [CMD_W-1:0]        cmd,
   input  logic [DATA_W-1:0]       dq,
   input  logic [1:0]              tbl_size,
   input  logic [2:0]              hit_lat,
   input  logic                    wr_en,
   input  logic [1:0]              wr_sel,
   input  logic [WAW-1:0]          wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic                    rd_sel,
   input  logic [PAIR_IDX_W-1:0]   rd_idx,
   output logic [2*DATA_W-1:0]     rd_data,
   output logic                    res_vld,
   output logic                    res_hit,
   output logic [RADDR_W-1:0]      res_addr,
   output logic [2:0]              res_ssr
);
   if (WORDS < 2 || (WORDS % 2) != 0) begin : g_bad_words
      $error("nse_search_top: WORDS must be even and at least 2");
   end
   if (PAIRS > (1 << (RLOW_W - 1))) begin : g_bad_depth
      $error("nse_search_top: table too deep for the address field");
   end
   if (2*DATA_W < RADDR_W + 1) begin : g_bad_width
      $error("nse_search_top: data width too small for result readback");
   end

   // command decode
   logic                  a_pend;
   logic [PAIR_IDX_W-1:0] a_gmr;
   logic [2:0]            a_hi;
   logic [DATA_W-1:0]     a_key;
   logic [PAIRS-1:0]      a_even;
   logic                  is_srch, start_a, do_b;

   assign is_srch = cmd_vld && (cmd[1:0] == CMD_SEARCH);
   assign start_a = is_srch && !a_pend && !cmd[2];
   assign do_b    = is_srch && a_pend;

   // mask registers
   logic [DATA_W-1:0] gmr_q [NMASK];
   logic [DATA_W-1:0] care;
   logic [PAIR_IDX_W-1:0] gmr_now;

   assign gmr_now = a_pend ? a_gmr : {cmd[10], cmd[5:3]};
   assign care    = gmr_q[{gmr_now, a_pend}];

   always_ff @(posedge clk) begin
      if (wr_en && wr_sel == WR_MASK)
         gmr_q[wr_addr[$clog2(NMASK)-1:0]] <= wr_data;
   end

   // compare bank
   logic [WORDS-1:0] word_hit;
   logic [PAIRS-1:0] even_now, odd_now, pair_hit;

   nse_match_bank #(.WORD_W(DATA_W), .WORDS(WORDS), .AW(WAW)) u_bank (
      .clk     (clk),
      .wr_en   (wr_en && wr_sel == WR_WORD),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .key     (dq),
      .care    (care),
      .hit     (word_hit)
   );

   generate
      for (genvar p = 0; p < PAIRS; p++) begin : g_pair
         assign even_now[p] = word_hit[2*p];
         assign odd_now[p]  = word_hit[2*p+1];
      end
   endgenerate

   assign pair_hit = a_even & odd_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_pend <= 1'b0;
         a_gmr  <= '0;
         a_hi   <= '0;
         a_key  <= '0;
         a_even <= '0;
      end else if (start_a) begin
         a_pend <= 1'b1;
         a_gmr  <= {cmd[10], cmd[5:3]};
         a_hi   <= cmd[8:6];
         a_key  <= dq;
         a_even <= even_now;
      end else begin
         a_pend <= 1'b0;
      end
   end

   // priority select
   logic           any_hit;
   logic [PIW-1:0] win;

   nse_prio_enc #(.N(PAIRS)) u_prio (
      .req (pair_hit),
      .any (any_hit),
      .idx (win)
   );

   nse_res_t launch, done;
   logic [RLOW_W-1:0] low_addr;

   assign low_addr = RLOW_W'(win) << 1;

   always_comb begin
      launch.vld  = do_b;
      launch.hit  = any_hit;
      launch.addr = any_hit ? {a_hi, low_addr} : '0;
      launch.ssr  = cmd[8:6];
   end

   nse_lat_pipe #(.BASE_S(BASE_S), .BASE_M(BASE_M), .BASE_L(BASE_L), .XTRA_W(3)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .tbl_size (tbl_size),
      .hit_lat  (hit_lat),
      .din      (launch),
      .dout     (done)
   );

   assign res_vld  = done.vld;
   assign res_hit  = done.hit;
   assign res_addr = done.addr;
   assign res_ssr  = done.ssr;

   // search-result registers
   logic [RADDR_W:0] ssr_q [SSR_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SSR_N; i++) ssr_q[i] <= '0;
      end else if (done.vld) begin
         ssr_q[done.ssr] <= {done.hit, done.addr};
      end
   end

   // comparand registers: capture issued after the port write wins
   logic [DATA_W-1:0] cmp_hi [NCMP];
   logic [DATA_W-1:0] cmp_lo [NCMP];

   always_ff @(posedge clk) begin
      if (wr_en && wr_sel == WR_CMP) begin
         if (!wr_addr[0]) cmp_hi[wr_addr[PAIR_IDX_W:1]] <= wr_data;
         else             cmp_lo[wr_addr[PAIR_IDX_W:1]] <= wr_data;
      end
      if (do_b) begin
         cmp_hi[cmd[5:2]] <= a_key;
         cmp_lo[cmd[5:2]] <= dq;
      end
   end

   always_comb begin
      if (rd_sel) rd_data = (2*DATA_W)'(ssr_q[rd_idx[2:0]]);
      else        rd_data = {cmp_hi[rd_idx], cmp_lo[rd_idx]};
   end

   // R1
   a_pend_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_pend |=> !a_pend);

   // R8
   isol_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_pend && is_srch && cmd[2]) |=> !a_pend);

   // R3
   even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && res_hit) |-> (res_addr[0] == 1'b0));

   // R6
   ssr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |=> (ssr_q[$past(res_ssr)] == $past({res_hit, res_addr})));

   // R9
   launch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch.vld |=> !launch.vld);
endmodule

// File: tb/nse_search_top_tb_top.sv
module nse_search_top_tb_top;
   localparam int W = 72;
   localparam int N = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_vld = 1'b0;
   logic [10:0] cmd = '0;
   logic [W-1:0] dq = '0;
   logic [1:0] tbl_size = 2'b00;
   logic [2:0] hit_lat = 3'd0;
   logic wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [4:0] wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic rd_sel = 1'b0;
   logic [3:0] rd_idx = '0;
   logic [2*W-1:0] rd_data;
   logic res_vld, res_hit;
   logic [23:0] res_addr;
   logic [2:0] res_ssr;

   nse_search_top dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd), .dq(dq),
      .tbl_size(tbl_size), .hit_lat(hit_lat), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_sel(rd_sel), .rd_idx(rd_idx),
      .rd_data(rd_data), .res_vld(res_vld), .res_hit(res_hit),
      .res_addr(res_addr), .res_ssr(res_ssr)
   );

   always #5 clk = ~clk;

   int nchk = 0, nfail = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int nlog = 0;
   int lg_cyc [256];
   logic lg_hit [256];
   logic [23:0] lg_addr [256];
   logic [2:0] lg_ssr [256];
   always @(negedge clk) begin
      if (rst_n && res_vld && nlog < 256) begin
         lg_cyc[nlog] = cyc; lg_hit[nlog] = res_hit;
         lg_addr[nlog] = res_addr; lg_ssr[nlog] = res_ssr;
         nlog = nlog + 1;
      end
   end

   logic [W-1:0] ent [N];
   logic [W-1:0] msk [32];

   task automatic chk(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [4:0] a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [W-1:0] pat(input int j);
      return {8'(j) ^ 8'h5A, {4{16'(j * 16'h1357 + 16'h0F0F)}}};
   endfunction

   // issues cycle A at one negedge and cycle B at the next; returns cyc of B
   task automatic search(input logic [3:0] g, input logic [2:0] hi, input logic [W-1:0] ka,
                         input logic [3:0] ci, input logic [2:0] si, input logic [W-1:0] kb,
                         input bit collide, output int tb);
      @(negedge clk);
      cmd_vld = 1'b1;
      cmd = {g[3], 1'b0, hi, g[2:0], 1'b0, 2'b10};
      dq = ka;
      @(negedge clk);
      cmd = {1'b0, 1'b0, si, ci, 2'b10};
      dq = kb;
      if (collide) begin
         wr_en = 1'b1; wr_sel = 2'd2; wr_addr = {ci, 1'b0}; wr_data = ~ka;
      end
      tb = cyc;
      @(negedge clk);
      cmd_vld = 1'b0; cmd = '0; wr_en = 1'b0;
   endtask

   // model of R2/R3/R4: returns hit flag and lowest even index
   task automatic model(input logic [3:0] g, input logic [W-1:0] ka, input logic [W-1:0] kb,
                        output bit h, output int idx);
      h = 1'b0; idx = 0;
      for (int p = N/2 - 1; p >= 0; p--) begin
         if ((((ent[2*p] ^ ka) & msk[2*g]) == '0) && (((ent[2*p+1] ^ kb) & msk[2*g+1]) == '0)) begin
            h = 1'b1; idx = 2*p;
         end
      end
   endtask

   function automatic int lat();
      case (tbl_size)
         2'b00: return 4 + int'(hit_lat);
         2'b01: return 5 + int'(hit_lat);
         default: return 6 + int'(hit_lat);
      endcase
   endfunction

   task automatic wait_cyc(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic expect_res(input string req, input int tb, input int l, input bit h,
                             input logic [23:0] a, input logic [2:0] s);
      int k = -1;
      bit early = 1'b0;
      wait_cyc(tb + l + 2);
      for (int i = 0; i < nlog; i++) begin
         if (lg_cyc[i] == tb + l) k = i;
         if (lg_cyc[i] == tb + l - 1) early = 1'b1;
      end
      chk(k >= 0 && !early, {req, " R5 result timing"}, 144'(k), 144'(l));
      if (k >= 0) begin
         chk(lg_hit[k] == h, {req, " hit flag"}, 144'(lg_hit[k]), 144'(h));
         if (h) chk(lg_addr[k] == a, {req, " address"}, 144'(lg_addr[k]), 144'(a));
         chk(lg_ssr[k] == s, {req, " R6 register index"}, 144'(lg_ssr[k]), 144'(s));
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin : main
      int tb, idx, n0;
      bit h;
      int tbs [3];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(res_vld == 1'b0, "R10 res_vld after reset", 144'(res_vld), 144'(0));
      rd_sel = 1'b1;
      for (int i = 0; i < 8; i++) begin
         rd_idx = 4'(i); #1;
         chk(rd_data == '0, "R10 result register cleared", rd_data, 144'(0));
      end
      // R11 load table and masks
      for (int j = 0; j < N; j++) begin ent[j] = pat(j); wr(2'd0, 5'(j), ent[j]); end
      for (int m = 0; m < 32; m++) msk[m] = '1;
      msk[2] = '0;               // pair 1: even half ignored
      msk[4] = '0; msk[5] = '0;  // pair 2: everything ignored
      msk[19] = {{(W-8){1'b0}}, 8'hFF}; // pair 9 odd: low byte only
      for (int m = 0; m < 32; m++) wr(2'd1, 5'(m), msk[m]);

      // R2 R3 sweep over every pair with full masks and random-ish prefixes
      for (int p = 0; p < N/2; p++) begin
         search(4'd0, 3'(p), ent[2*p], 4'(p), 3'(p), ent[2*p+1], 1'b0, tb);
         model(4'd0, ent[2*p], ent[2*p+1], h, idx);
         expect_res("R2 R3 single pair sweep", tb, lat(), h, {3'(p), 21'(idx)}, 3'(p));
         chk(h && idx == 2*p, "R2 model sanity", 144'(idx), 144'(2*p));
      end
      // R4 half mismatch: upper half of pair 2, lower half of pair 5
      search(4'd0, 3'd1, ent[4], 4'd1, 3'd4, ent[11], 1'b0, tb);
      expect_res("R4 split halves miss", tb, lat(), 1'b0, 24'd0, 3'd4);
      // R2 even mask zero: only odd half matters
      search(4'd1, 3'd2, '1, 4'd2, 3'd5, ent[13], 1'b0, tb);
      expect_res("R2 even mask ignored", tb, lat(), 1'b1, {3'd2, 21'd12}, 3'd5);
      // R3 all masks zero: every pair hits, lowest wins
      search(4'd2, 3'd7, '0, 4'd3, 3'd6, '1, 1'b0, tb);
      expect_res("R3 lowest of all", tb, lat(), 1'b1, {3'd7, 21'd0}, 3'd6);
      // R3 two hits via duplicated odd word, pair index using cmd bit 10 (g=9)
      ent[11] = ent[7]; wr(2'd0, 5'd11, ent[11]);
      search(4'd9, 3'd3, ent[10], 4'd4, 3'd7, ent[7] ^ {8'hAA, 64'd0}, 1'b0, tb);
      model(4'd9, ent[10], ent[7] ^ {8'hAA, 64'd0}, h, idx);
      expect_res("R3 masked low byte match", tb, lat(), h, {3'd3, 21'(idx)}, 3'd7);
      ent[10] = ent[6]; wr(2'd0, 5'd10, ent[10]);
      search(4'd0, 3'd5, ent[6], 4'd5, 3'd0, ent[7], 1'b0, tb);
      expect_res("R3 two hits lowest wins", tb, lat(), 1'b1, {3'd5, 21'd6}, 3'd0);

      // R6 readback of the last result
      rd_sel = 1'b1; rd_idx = 4'd0; #1;
      chk(rd_data[24:0] == {1'b1, 3'd5, 21'd6}, "R6 result register readback", rd_data, 144'({1'b1, 3'd5, 21'd6}));
      rd_idx = 4'd4; #1;
      chk(rd_data[24:0] == 25'd0, "R6 miss stored in register 4", rd_data, 144'(0));

      // R7 capture readback and R11 comparand write
      rd_sel = 1'b0; rd_idx = 4'd5; #1;
      chk(rd_data == {ent[6], ent[7]}, "R7 comparand capture", rd_data, {ent[6], ent[7]});
      wr(2'd2, {4'd9, 1'b0}, pat(40)); wr(2'd2, {4'd9, 1'b1}, pat(41));
      rd_idx = 4'd9; #1;
      chk(rd_data == {pat(40), pat(41)}, "R11 comparand port write", rd_data, {pat(40), pat(41)});
      search(4'd0, 3'd0, ent[0], 4'd9, 3'd1, ent[1], 1'b1, tb);
      #1;
      chk(rd_data == {ent[0], ent[1]}, "R7 capture wins over same-cycle write", rd_data, {ent[0], ent[1]});
      expect_res("R7 collision search", tb, lat(), 1'b1, 24'd0, 3'd1);

      // R5 latency sweep
      for (int t = 0; t < 4; t++) begin
         for (int x = 0; x < 8; x++) begin
            @(negedge clk); tbl_size = 2'(t); hit_lat = 3'(x);
            search(4'd0, 3'd6, ent[2], 4'd0, 3'(x), ent[3], 1'b0, tb);
            expect_res("R5 latency sweep", tb, lat(), 1'b1, {3'd6, 21'd2}, 3'(x));
            wait_cyc(tb + lat() + 3);
            n0 = 0;
            for (int i = 0; i < nlog; i++) if (lg_cyc[i] == tb + lat() + 1) n0++;
            chk(n0 == 0, "R5 single-cycle pulse", 144'(n0), 144'(0));
         end
      end
      tbl_size = 2'b01; hit_lat = 3'd2;

      // R8 isolated second cycle, R1 abandoned first cycle
      n0 = nlog;
      @(negedge clk); cmd_vld = 1'b1; cmd = {3'b000, 3'd2, 4'b1111, 2'b10}; dq = ent[1];
      @(negedge clk); cmd_vld = 1'b0; cmd = '0;
      repeat (20) @(negedge clk);
      chk(nlog == n0, "R8 lone second cycle ignored", 144'(nlog), 144'(n0));
      @(negedge clk); cmd_vld = 1'b1; cmd = {1'b0, 1'b0, 3'd1, 3'd0, 1'b0, 2'b10}; dq = ent[0];
      @(negedge clk); cmd_vld = 1'b0; cmd = {1'b0, 1'b0, 3'd3, 4'd0, 2'b10};
      @(negedge clk); cmd = '0;
      repeat (20) @(negedge clk);
      chk(nlog == n0, "R1 abandoned first cycle", 144'(nlog), 144'(n0));

      // R9 back-to-back searches every two cycles
      n0 = nlog;
      @(negedge clk);
      for (int s = 0; s < 3; s++) begin
         cmd_vld = 1'b1; cmd = {1'b0, 1'b0, 3'(s), 3'd0, 1'b0, 2'b10}; dq = ent[4*s];
         @(negedge clk);
         cmd = {1'b0, 1'b0, 3'(s+2), 4'(s), 2'b10}; dq = ent[4*s+1];
         tbs[s] = cyc;
         @(negedge clk);
      end
      cmd_vld = 1'b0; cmd = '0;
      wait_cyc(tbs[2] + lat() + 2);
      chk(nlog == n0 + 3, "R9 three results", 144'(nlog - n0), 144'(3));
      for (int s = 0; s < 3; s++) begin
         if (n0 + s < nlog) begin
            chk(lg_cyc[n0+s] == tbs[s] + lat() && lg_addr[n0+s] == {3'(s), 21'(4*s)} && lg_ssr[n0+s] == 3'(s+2),
                "R9 in-order result", 144'({lg_addr[n0+s], lg_ssr[n0+s]}), 144'({3'(s), 21'(4*s), 3'(s+2)}));
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule